// File: doc/BRIEF.md
# Stereo Digital Routing Mixer

This block combines the digital audio sources of a codec into four channel outputs. A playback section builds the left and right DAC samples and a capture section builds the left and right record slots of the serial port. Each channel has four sources, and each source has one enable bit. A disabled source adds nothing. The enabled sources are summed and the result is saturated to the signed sample range.

All inputs are signed samples. They are taken together on a single cycle strobe, and the results appear, with a valid flag, on the following clock. The capture section includes a crossed source: the second interface's opposite channel feeds each record slot. Path enables and slot enables force outputs to zero, or remove the slot-0 input, without changing the routing bits. The enable bits keep their positions in a 16-bit control word, so a register file nearby can hand the upper byte straight through.

Top module: `stereo_route_mixer`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released until the first strobe, all four outputs are zero and out_vld is low.
- R2: out_vld is high in exactly the cycle after a cycle with smp_vld high. Outputs change only on that edge and otherwise hold their value.
- R3: dac_l is the saturated sum of the sources whose pb_route bits are set. Bit 15 selects slot-0 left, bit 14 selects slot-1 left, bit 13 selects second interface left and bit 12 selects ADC left.
- R4: dac_r uses pb_route bits 11:8 in the same order over the right-channel sources. Bit 11 selects slot-0 right and bit 8 selects ADC right.
- R5: rec_l uses cap_route bits 15:12. Bit 15 selects slot-0 left, bit 14 selects second interface left, bit 13 selects ADC left and bit 12 selects second interface right.
- R6: rec_r uses cap_route bits 11:8. Bit 11 selects slot-0 right, bit 10 selects second interface right, bit 9 selects ADC right and bit 8 selects second interface left, which is the crossed source.
- R7: A sum above 32767 gives 32767. A sum below -32768 gives -32768.
- R8: When dac_en is low at a strobe, dac_l and dac_r become zero. The ADC source still counts in the playback sums.
- R9: When adc_en is low at a strobe, rec_l and rec_r become zero.
- R10: When rec_slot_en[1] is low at a strobe, rec_l becomes zero. When rec_slot_en[0] is low, rec_r becomes zero.
- R11: When play_slot_en[1] is low, the slot-0 left input adds nothing to either section. When play_slot_en[0] is low, the slot-0 right input adds nothing to either section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| smp_vld | input | 1 | strobe: all sample inputs are valid |
| pb_route | input | 8 | playback enables, bits 15:8 of the control word |
| cap_route | input | 8 | capture enables, bits 15:8 of the control word |
| dac_en | input | 1 | playback path enable |
| adc_en | input | 1 | capture path enable |
| play_slot_en | input | 2 | slot-0 input enables, [1] left, [0] right |
| rec_slot_en | input | 2 | record slot enables, [1] left, [0] right |
| s0_l | input | 16 | serial slot 0 left |
| s0_r | input | 16 | serial slot 0 right |
| s1_l | input | 16 | serial slot 1 left |
| s1_r | input | 16 | serial slot 1 right |
| if2_l | input | 16 | second interface left |
| if2_r | input | 16 | second interface right |
| adc_l | input | 16 | ADC left |
| adc_r | input | 16 | ADC right |
| dac_l | output | 16 | playback left result |
| dac_r | output | 16 | playback right result |
| rec_l | output | 16 | record left result |
| rec_r | output | 16 | record right result |
| out_vld | output | 1 | results valid |

## Verification
Every source is given a distinct magnitude, and the sign differs between channels. With those inputs, each of the 16 enable codes per channel gives its own sum, so a swapped bit, a swapped channel or a wrong crossed source shows up as a wrong value. Large inputs of both signs drive the sums beyond each limit to show clamping rather than wraparound. Gating tests flip one enable at a time with routing fixed, which separates path, slot and input gating. Strobe-free cycles show that the outputs hold.

// File: rtl/stereo_route_mixer.sv
module stereo_route_mixer #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [15:8]         pb_route,
  input  logic [15:8]         cap_route,
  input  logic                dac_en,
  input  logic                adc_en,
  input  logic [1:0]          play_slot_en,
  input  logic [1:0]          rec_slot_en,
  input  logic signed [W-1:0] s0_l,
  input  logic signed [W-1:0] s0_r,
  input  logic signed [W-1:0] s1_l,
  input  logic signed [W-1:0] s1_r,
  input  logic signed [W-1:0] if2_l,
  input  logic signed [W-1:0] if2_r,
  input  logic signed [W-1:0] adc_l,
  input  logic signed [W-1:0] adc_r,
  output logic signed [W-1:0] dac_l,
  output logic signed [W-1:0] dac_r,
  output logic signed [W-1:0] rec_l,
  output logic signed [W-1:0] rec_r,
  output logic                out_vld
);
  localparam int SW = W + 2;
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

  function automatic logic signed [SW-1:0] ext(input logic on, input logic signed [W-1:0] x);
    return on ? {{2{x[W-1]}}, x} : '0;
  endfunction

  function automatic logic signed [W-1:0] mix4(input logic [3:0] en,
      input logic signed [W-1:0] a, input logic signed [W-1:0] b,
      input logic signed [W-1:0] c, input logic signed [W-1:0] d);
    logic signed [SW-1:0] acc;
    acc = ext(en[3], a) + ext(en[2], b) + ext(en[1], c) + ext(en[0], d);
    if (acc > MAXV) return MAXV[W-1:0];
    if (acc < MINV) return MINV[W-1:0];
    return acc[W-1:0];
  endfunction

  logic signed [W-1:0] s0l_g, s0r_g;
  assign s0l_g = play_slot_en[1] ? s0_l : '0;
  assign s0r_g = play_slot_en[0] ? s0_r : '0;

  logic signed [W-1:0] pl_n, pr_n, cl_n, cr_n;
  assign pl_n = dac_en ? mix4(pb_route[15:12], s0l_g, s1_l, if2_l, adc_l) : '0;
  assign pr_n = dac_en ? mix4(pb_route[11:8],  s0r_g, s1_r, if2_r, adc_r) : '0;
  assign cl_n = (adc_en && rec_slot_en[1]) ? mix4(cap_route[15:12], s0l_g, if2_l, adc_l, if2_r) : '0;
  assign cr_n = (adc_en && rec_slot_en[0]) ? mix4(cap_route[11:8],  s0r_g, if2_r, adc_r, if2_l) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      dac_l <= '0;
      dac_r <= '0;
      rec_l <= '0;
      rec_r <= '0;
    end else begin
      out_vld <= smp_vld;
      if (smp_vld) begin
        dac_l <= pl_n;
        dac_r <= pr_n;
        rec_l <= cl_n;
        rec_r <= cr_n;
      end
    end
  end

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) smp_vld |=> out_vld); // R2
  AST_VLD_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> !out_vld); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp_vld |=> $stable({dac_l, dac_r, rec_l, rec_r})); // R2
  AST_DAC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && !dac_en) |=> (dac_l == '0 && dac_r == '0)); // R8
  AST_ADC_OFF: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && !adc_en) |=> (rec_l == '0 && rec_r == '0)); // R9
  AST_REC_SLOT_L: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && !rec_slot_en[1]) |=> rec_l == '0); // R10
  AST_REC_SLOT_R: assert property (@(posedge clk) disable iff (!rst_n) (smp_vld && !rec_slot_en[0]) |=> rec_r == '0); // R10
endmodule

// File: tb/test_stereo_route_mixer.sv
module test_stereo_route_mixer;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic [15:8] pb_route = '0, cap_route = '0;
  logic dac_en = 1'b1, adc_en = 1'b1;
  logic [1:0] play_slot_en = 2'b11, rec_slot_en = 2'b11;
  logic signed [15:0] s0_l = 0, s0_r = 0, s1_l = 0, s1_r = 0;
  logic signed [15:0] if2_l = 0, if2_r = 0, adc_l = 0, adc_r = 0;
  logic signed [15:0] dac_l, dac_r, rec_l, rec_r;
  logic out_vld;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  stereo_route_mixer i_stereo_route_mixer (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic int pick(input logic [3:0] en, input int a, input int b, input int c, input int d);
    return sat((en[3] ? a : 0) + (en[2] ? b : 0) + (en[1] ? c : 0) + (en[0] ? d : 0));
  endfunction

  task automatic strobe();
    @(negedge clk) smp_vld = 1'b1;
    @(negedge clk) smp_vld = 1'b0;
  endtask

  task automatic load(input int a, input int b, input int c, input int d,
                      input int e, input int f, input int g, input int h);
    s0_l = 16'(a); s0_r = 16'(b); s1_l = 16'(c); s1_r = 16'(d);
    if2_l = 16'(e); if2_r = 16'(f); adc_l = 16'(g); adc_r = 16'(h);
  endtask

  task automatic t_reset();
    chk("R1 dac_l", dac_l, 0); chk("R1 dac_r", dac_r, 0);
    chk("R1 rec_l", rec_l, 0); chk("R1 rec_r", rec_r, 0);
    chk("R1 out_vld", out_vld, 0);
  endtask

  task automatic t_routing();
    load(1000, -1001, 200, -202, 30, -33, 4, -5);
    for (int e = 0; e < 16; e++) begin
      pb_route = {4'(e), 4'(15 - e)};
      cap_route = {4'(15 - e), 4'(e)};
      strobe();
      chk("R2 out_vld", out_vld, 1);
      chk("R3 dac_l", dac_l, pick(4'(e), 1000, 200, 30, 4));
      chk("R4 dac_r", dac_r, pick(4'(15 - e), -1001, -202, -33, -5));
      chk("R5 rec_l", rec_l, pick(4'(15 - e), 1000, 30, 4, -33));
      chk("R6 rec_r", rec_r, pick(4'(e), -1001, -33, -5, 30));
    end
  endtask

  task automatic t_hold();
    int hl;
    hl = dac_l;
    load(7, 7, 7, 7, 7, 7, 7, 7);
    @(negedge clk);
    chk("R2 vld low", out_vld, 0);
    chk("R2 hold", dac_l, hl);
  endtask

  task automatic t_saturate();
    pb_route = 8'hFF; cap_route = 8'hFF;
    load(30000, -30000, 20000, -20000, 10000, -10000, 5, -5);
    strobe();
    chk("R7 dac_l hi", dac_l, 32767);
    chk("R7 dac_r lo", dac_r, -32768);
    chk("R7 rec_l", rec_l, sat(30000 + 10000 + 5 - 10000));
    chk("R7 rec_r", rec_r, sat(-30000 - 10000 - 5 + 10000));
    load(-20000, 20000, -20000, 20000, 100, -100, 0, 0);
    pb_route = 8'hCC; cap_route = 8'hFF;
    strobe();
    chk("R7 dac_l lo", dac_l, -32768);
    chk("R7 dac_r hi", dac_r, 32767);
  endtask

  task automatic t_gates();
    load(1000, -1000, 200, -200, 30, -30, 4, -4);
    pb_route = 8'hFF; cap_route = 8'hFF;
    dac_en = 1'b0; strobe();
    chk("R8 dac_l", dac_l, 0); chk("R8 dac_r", dac_r, 0);
    chk("R8 rec_l kept", rec_l, 1004);
    dac_en = 1'b1; adc_en = 1'b0; strobe();
    chk("R9 rec_l", rec_l, 0); chk("R9 rec_r", rec_r, 0);
    chk("R8 dac adc src", dac_l, 1234);
    adc_en = 1'b1; rec_slot_en = 2'b01; strobe();
    chk("R10 rec_l", rec_l, 0); chk("R10 rec_r", rec_r, -1004);
    rec_slot_en = 2'b10; strobe();
    chk("R10 rec_r", rec_r, 0); chk("R10 rec_l", rec_l, 1004);
    rec_slot_en = 2'b11; play_slot_en = 2'b01; strobe();
    chk("R11 dac_l", dac_l, 234); chk("R11 rec_l", rec_l, 4);
    chk("R11 dac_r", dac_r, -1234);
    play_slot_en = 2'b10; strobe();
    chk("R11 dac_r", dac_r, -234); chk("R11 rec_r", rec_r, -4);
    play_slot_en = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_routing();
    t_hold();
    t_saturate();
    t_gates();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule